// File: doc/BRIEF.md
# Pointer Register Address Generator

This block works out the effective memory address for indirect loads and stores. The pointer can be one of three 16-bit pointers, X, Y or Z. The register file assembles each pointer from two 8-bit registers and presents all three on the inputs. A request gives a pointer select, an addressing mode, an unsigned 6-bit displacement, a 16-bit direct address and an operation kind (data load, data store or program-memory read). A start strobe launches it. The block then drives the address together with a single read, write or program-read strobe. In that same cycle it also drives the new pointer value, a write enable and the index of the low register of the pair to be written back.

The modes are:
- plain indirect;
- post-increment, which accesses at the old pointer and writes back pointer+1;
- pre-decrement, which computes pointer−1, accesses at it and writes it back;
- displacement, which accesses at pointer+q, is legal on Y and Z only and never writes back;
- direct, which uses the 16-bit address from the request and ignores the pointer.

Program-memory reads use Z, either plain or post-incremented. Illegal combinations raise a one-cycle flag. In that case no access and no writeback take place.

A state machine sequences the work. Its states are IDLE, ACCESS, HOLD, DONE and FAULT.
- IDLE to ACCESS on a legal start, or IDLE to FAULT on an illegal start.
- ACCESS to DONE for data operations, or ACCESS to HOLD for program reads.
- HOLD to DONE.
- DONE to IDLE, and FAULT to IDLE.

Data operations take two cycles (ACCESS, DONE). Program reads take three (ACCESS, HOLD, DONE).

Top module: `ptr_addr_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after release, busy, done, illegal, mem_rd, mem_wr, prog_rd and ptr_we are all 0.
- R2: Plain mode (mode=0) addresses memory at the selected pointer (ptr_sel 0=X, 1=Y, 2=Z) and leaves ptr_we at 0.
- R3: Post-increment mode (mode=1) addresses memory at the current pointer. In the same cycle it drives ptr_we=1 with ptr_wdata equal to pointer+1 modulo 2^16.
- R4: Pre-decrement mode (mode=2) addresses memory at pointer−1 modulo 2^16. In the same cycle it writes that same value back with ptr_we=1.
- R5: Displacement mode (mode=3) addresses memory at pointer+disp, with disp unsigned 0..63 and the sum taken modulo 2^16. It is legal with Y or Z only and leaves ptr_we at 0.
- R6: Direct mode (mode=4) addresses memory at direct_addr whatever ptr_sel is, and leaves ptr_we at 0.
- R7: Each of the following raises illegal for exactly one cycle after start:
  - displacement with X;
  - ptr_sel=3 outside direct mode;
  - mode codes 5 to 7;
  - op_kind=3;
  - a program read that is not Z in mode 0 or 1.

  That cycle has no memory strobe, no writeback and no done, and busy is 0 in the cycle after it.
- R8: A legal data request (op_kind 0=load, 1=store) strobes mem_rd or mem_wr in the cycle after start, and asserts done in the following cycle.
- R9: A legal program read (op_kind=2) strobes prog_rd in the cycle after start, holds a quiet cycle, and then asserts done.
- R10: A start that arrives while busy is ignored: the address captured for the running request is kept until done.
- R11: A writeback names the low register of its pair: 26 for X, 28 for Y, 30 for Z.
- R12: At most one of mem_rd, mem_wr, prog_rd and illegal is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a request (taken only when idle) |
| op_kind | input | 2 | 0 data load, 1 data store, 2 program read, 3 illegal |
| ptr_sel | input | 2 | 0 X, 1 Y, 2 Z, 3 none |
| mode | input | 3 | 0 plain, 1 post-inc, 2 pre-dec, 3 displacement, 4 direct |
| disp | input | 6 | Unsigned displacement |
| direct_addr | input | 16 | Direct address |
| ptr_x | input | 16 | Pointer X from register pair 27:26 |
| ptr_y | input | 16 | Pointer Y from register pair 29:28 |
| ptr_z | input | 16 | Pointer Z from register pair 31:30 |
| busy | output | 1 | Request in progress |
| done | output | 1 | Last cycle of a legal request |
| illegal | output | 1 | Illegal combination flag |
| mem_addr | output | 16 | Effective address |
| mem_rd | output | 1 | Data memory read strobe |
| mem_wr | output | 1 | Data memory write strobe |
| prog_rd | output | 1 | Program memory read strobe |
| ptr_we | output | 1 | Pointer writeback enable |
| ptr_wdata | output | 16 | New pointer value |
| ptr_wsel | output | 5 | Low register index of the pair written back |

## Verification
The assertions check five things on every cycle: strobes are mutually exclusive, a data strobe is followed by done, a program strobe is followed by done two cycles later, and an illegal cycle has no writeback and is followed by idle. Any writeback must name an even pair register from 26 to 30 and coincide with an access strobe. The exact address and pointer arithmetic, including wraparound at 0x0000 and 0xFFFF, can only be shown by the bench's sweep over every kind, pointer, mode and displacement corner. The bench scenarios alone also cover ignoring a start while busy.

// File: rtl/ptrgen_pkg.sv
package ptrgen_pkg;
    localparam logic [1:0] OPK_LOAD  = 2'd0;
    localparam logic [1:0] OPK_STORE = 2'd1;
    localparam logic [1:0] OPK_PROG  = 2'd2;

    localparam logic [1:0] SEL_X = 2'd0;
    localparam logic [1:0] SEL_Y = 2'd1;
    localparam logic [1:0] SEL_Z = 2'd2;

    localparam logic [2:0] AM_PLAIN   = 3'd0;
    localparam logic [2:0] AM_POSTINC = 3'd1;
    localparam logic [2:0] AM_PREDEC  = 3'd2;
    localparam logic [2:0] AM_DISP    = 3'd3;
    localparam logic [2:0] AM_DIRECT  = 3'd4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACCESS,
        ST_HOLD,
        ST_DONE,
        ST_FAULT
    } pg_state_e;
endpackage

// File: rtl/ptrgen_select.sv
module ptrgen_select #(
    parameter int AW        = 16,
    parameter int RIW       = 5,
    parameter int PAIR_BASE = 26
) (
    input  logic [1:0]     sel,
    input  logic [AW-1:0]  ptr_x,
    input  logic [AW-1:0]  ptr_y,
    input  logic [AW-1:0]  ptr_z,
    output logic [AW-1:0]  ptr,
    output logic [RIW-1:0] pair_lo
);
    localparam int NPTR = 3;

    logic [AW-1:0] bank [NPTR];

    assign bank[0] = ptr_x;
    assign bank[1] = ptr_y;
    assign bank[2] = ptr_z;

    always_comb begin
        ptr = '0;
        for (int i = 0; i < NPTR; i++) begin
            if (sel == 2'(i)) ptr = bank[i];
        end
    end

    assign pair_lo = RIW'(PAIR_BASE) + RIW'({sel, 1'b0});
endmodule

// File: rtl/ptrgen_ea.sv
module ptrgen_ea
    import ptrgen_pkg::*;
#(
    parameter int AW = 16,
    parameter int QW = 6
) (
    input  logic [1:0]    kind,
    input  logic [1:0]    sel,
    input  logic [2:0]    mode,
    input  logic [QW-1:0] disp,
    input  logic [AW-1:0] direct_addr,
    input  logic [AW-1:0] ptr,
    output logic [AW-1:0] ea,
    output logic [AW-1:0] wb,
    output logic          wb_en,
    output logic          bad
);
    localparam int PADW = AW - QW;

    logic [AW-1:0] inc_v, dec_v, off_v;
    logic          mode_bad, sel_bad, kind_bad;

    assign inc_v = ptr + AW'(1);
    assign dec_v = ptr - AW'(1);
    assign off_v = ptr + {{PADW{1'b0}}, disp};

    always_comb begin
        ea       = ptr;
        wb       = ptr;
        wb_en    = 1'b0;
        mode_bad = 1'b0;
        unique case (mode)
            AM_PLAIN:   ea = ptr;
            AM_POSTINC: begin ea = ptr;   wb = inc_v; wb_en = 1'b1; end
            AM_PREDEC:  begin ea = dec_v; wb = dec_v; wb_en = 1'b1; end
            AM_DISP:    ea = off_v;
            AM_DIRECT:  ea = direct_addr;
            default:    mode_bad = 1'b1;
        endcase
    end

    always_comb begin
        sel_bad = 1'b0;
        if (mode != AM_DIRECT && sel == 2'd3) sel_bad = 1'b1;
        if (mode == AM_DISP && sel == SEL_X)  sel_bad = 1'b1;
    end

    always_comb begin
        kind_bad = 1'b0;
        if (kind == 2'd3) kind_bad = 1'b1;
        if (kind == OPK_PROG &&
            (sel != SEL_Z || (mode != AM_PLAIN && mode != AM_POSTINC)))
            kind_bad = 1'b1;
    end

    assign bad = mode_bad | sel_bad | kind_bad;
endmodule

// File: rtl/ptr_addr_gen.sv
module ptr_addr_gen
    import ptrgen_pkg::*;
#(
    parameter int AW        = 16,
    parameter int QW        = 6,
    parameter int RIW       = 5,
    parameter int PAIR_BASE = 26
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [1:0]     op_kind,
    input  logic [1:0]     ptr_sel,
    input  logic [2:0]     mode,
    input  logic [QW-1:0]  disp,
    input  logic [AW-1:0]  direct_addr,
    input  logic [AW-1:0]  ptr_x,
    input  logic [AW-1:0]  ptr_y,
    input  logic [AW-1:0]  ptr_z,
    output logic           busy,
    output logic           done,
    output logic           illegal,
    output logic [AW-1:0]  mem_addr,
    output logic           mem_rd,
    output logic           mem_wr,
    output logic           prog_rd,
    output logic           ptr_we,
    output logic [AW-1:0]  ptr_wdata,
    output logic [RIW-1:0] ptr_wsel
);
    pg_state_e state_q, state_d;

    logic [AW-1:0]  sel_ptr, ea_c, wb_c;
    logic [RIW-1:0] pair_c;
    logic           wben_c, bad_c;

    logic [AW-1:0]  addr_q, wb_q;
    logic [RIW-1:0] wsel_q;
    logic [1:0]     kind_q;
    logic           wben_q;
    logic           take;

    ptrgen_select #(.AW(AW), .RIW(RIW), .PAIR_BASE(PAIR_BASE)) u_sel (
        .sel     (ptr_sel),
        .ptr_x   (ptr_x),
        .ptr_y   (ptr_y),
        .ptr_z   (ptr_z),
        .ptr     (sel_ptr),
        .pair_lo (pair_c)
    );

    ptrgen_ea #(.AW(AW), .QW(QW)) u_ea (
        .kind        (op_kind),
        .sel         (ptr_sel),
        .mode        (mode),
        .disp        (disp),
        .direct_addr (direct_addr),
        .ptr         (sel_ptr),
        .ea          (ea_c),
        .wb          (wb_c),
        .wb_en       (wben_c),
        .bad         (bad_c)
    );

    assign take = (state_q == ST_IDLE) && start;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = bad_c ? ST_FAULT : ST_ACCESS;
            ST_ACCESS: state_d = (kind_q == OPK_PROG) ? ST_HOLD : ST_DONE;
            ST_HOLD:   state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            ST_FAULT:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            wb_q   <= '0;
            wsel_q <= '0;
            kind_q <= OPK_LOAD;
            wben_q <= 1'b0;
        end else if (take) begin
            addr_q <= ea_c;
            wb_q   <= wb_c;
            wsel_q <= pair_c;
            kind_q <= op_kind;
            wben_q <= wben_c & ~bad_c;
        end
    end

    always_comb begin
        busy    = (state_q != ST_IDLE);
        done    = 1'b0;
        illegal = 1'b0;
        mem_rd  = 1'b0;
        mem_wr  = 1'b0;
        prog_rd = 1'b0;
        ptr_we  = 1'b0;
        unique case (state_q)
            ST_ACCESS: begin
                mem_rd  = (kind_q == OPK_LOAD);
                mem_wr  = (kind_q == OPK_STORE);
                prog_rd = (kind_q == OPK_PROG);
                ptr_we  = wben_q;
            end
            ST_DONE:  done    = 1'b1;
            ST_FAULT: illegal = 1'b1;
            default: ;
        endcase
    end

    assign mem_addr  = addr_q;
    assign ptr_wdata = wb_q;
    assign ptr_wsel  = wsel_q;
endmodule

// File: rtl/ptr_addr_gen_chk.sv
module ptr_addr_gen_chk #(
    parameter int RIW = 5
) (
    input logic           clk,
    input logic           rst_n,
    input logic           busy,
    input logic           done,
    input logic           illegal,
    input logic           mem_rd,
    input logic           mem_wr,
    input logic           prog_rd,
    input logic           ptr_we,
    input logic [RIW-1:0] ptr_wsel
);
    p_one_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd, mem_wr, prog_rd, illegal}));

    p_data_then_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |=> done);

    p_prog_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        prog_rd |=> (busy && !done && !prog_rd));

    p_prog_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        prog_rd |-> ##2 done);

    p_fault_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!ptr_we && !done));

    p_fault_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> !busy);

    p_we_with_access_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_we |-> (mem_rd || mem_wr || prog_rd));

    p_pair_index_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_we |-> (ptr_wsel == RIW'(26) || ptr_wsel == RIW'(28) || ptr_wsel == RIW'(30)));

    p_done_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
endmodule

bind ptr_addr_gen ptr_addr_gen_chk #(.RIW(RIW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .illegal  (illegal),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .prog_rd  (prog_rd),
    .ptr_we   (ptr_we),
    .ptr_wsel (ptr_wsel)
);

// File: tb/ptr_addr_gen_bench.sv
`timescale 1ns/1ps
module ptr_addr_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op_kind = '0;
    logic [1:0]  ptr_sel = '0;
    logic [2:0]  mode = '0;
    logic [5:0]  disp = '0;
    logic [15:0] direct_addr = '0;
    logic [15:0] ptr_x = '0, ptr_y = '0, ptr_z = '0;
    logic        busy, done, illegal, mem_rd, mem_wr, prog_rd, ptr_we;
    logic [15:0] mem_addr, ptr_wdata;
    logic [4:0]  ptr_wsel;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ptr_addr_gen u_ptr_addr_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .op_kind(op_kind),
        .ptr_sel(ptr_sel), .mode(mode), .disp(disp), .direct_addr(direct_addr),
        .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z),
        .busy(busy), .done(done), .illegal(illegal), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .prog_rd(prog_rd),
        .ptr_we(ptr_we), .ptr_wdata(ptr_wdata), .ptr_wsel(ptr_wsel)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic string mode_tag(input int m);
        case (m)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic do_op(input int kind, input int sel, input int m, input int q,
                         input int base, input int k);
        bit legal;
        int p, ea, wb, wsel;
        bit we;
        int strobes;
        ptr_x = 16'(base);
        ptr_y = 16'(base ^ 16'h00F0);
        ptr_z = 16'(base + 16'h0101);
        p = (sel == 0) ? int'(ptr_x) : (sel == 1) ? int'(ptr_y) : int'(ptr_z);
        legal = 1'b1;
        if (kind == 3) legal = 1'b0;
        if (m > 4) legal = 1'b0;
        if (m != 4 && sel == 3) legal = 1'b0;
        if (m == 3 && sel == 0) legal = 1'b0;
        if (kind == 2 && !(sel == 2 && (m == 0 || m == 1))) legal = 1'b0;
        we = (m == 1 || m == 2);
        wb = (m == 1) ? ((p + 1) % 65536) : ((p + 65535) % 65536);
        case (m)
            2: ea = wb;
            3: ea = (p + q) % 65536;
            4: ea = k;
            default: ea = p;
        endcase
        wsel = 26 + 2 * sel;

        @(negedge clk);
        op_kind = 2'(kind); ptr_sel = 2'(sel); mode = 3'(m);
        disp = 6'(q); direct_addr = 16'(k); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        strobes = int'(mem_rd) + int'(mem_wr) + int'(prog_rd) + int'(illegal);
        chk(strobes <= 1, "R12 one strobe", strobes, 1);
        if (!legal) begin
            chk(illegal && !mem_rd && !mem_wr && !prog_rd && !ptr_we && !done,
                "R7 fault cycle", {illegal, mem_rd, mem_wr, prog_rd, ptr_we, done}, 32);
            @(negedge clk);
            chk(!busy && !illegal, "R7 back to idle", {busy, illegal}, 0);
            return;
        end
        chk(!illegal, "R7 no fault on legal", illegal, 0);
        chk(mem_rd == (kind == 0) && mem_wr == (kind == 1) && prog_rd == (kind == 2),
            kind == 2 ? "R9 strobe" : "R8 strobe", {mem_rd, mem_wr, prog_rd}, kind);
        chk(mem_addr == 16'(ea), mode_tag(m), mem_addr, ea);
        chk(ptr_we == we, (m == 1) ? "R3 we" : (m == 2) ? "R4 we" : "R2 no we", ptr_we, we);
        if (we) begin
            chk(ptr_wdata == 16'(wb), (m == 1) ? "R3 wdata" : "R4 wdata", ptr_wdata, wb);
            chk(ptr_wsel == 5'(wsel), "R11 pair", ptr_wsel, wsel);
        end
        @(negedge clk);
        if (kind == 2) begin
            chk(busy && !done && !prog_rd && !ptr_we, "R9 hold cycle", {busy, done, prog_rd}, 4);
            @(negedge clk);
        end
        chk(done && busy, kind == 2 ? "R9 done" : "R8 done", done, 1);
        @(negedge clk);
        chk(!busy && !done, "R8 idle after done", busy, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int bases[4];
        int qs[3];
        bases = '{0, 65535, 32705, 32768};
        qs = '{0, 63, 17};
        repeat (3) @(negedge clk);
        chk(!busy && !done && !illegal && !mem_rd && !mem_wr && !prog_rd && !ptr_we,
            "R1 in reset", {busy, done, illegal, mem_rd, mem_wr, prog_rd, ptr_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !mem_rd && !mem_wr && !prog_rd && !ptr_we, "R1 after reset", busy, 0);

        for (int kd = 0; kd < 4; kd++)
            for (int s = 0; s < 4; s++)
                for (int m = 0; m < 8; m++)
                    for (int b = 0; b < 4; b++)
                        for (int qi = 0; qi < 3; qi++)
                            do_op(kd, s, m, qs[qi], bases[b], (bases[b] ^ 16'h5A5A) + qi);

        // R10: start raised while a request is running is ignored
        @(negedge clk);
        ptr_y = 16'h1000; op_kind = 2'd0; ptr_sel = 2'd1; mode = 3'd3; disp = 6'd5;
        start = 1'b1;
        @(negedge clk);
        chk(mem_rd && mem_addr == 16'h1005, "R10 first access", mem_addr, 16'h1005);
        mode = 3'd4; direct_addr = 16'hBEEF; op_kind = 2'd1;
        @(negedge clk);
        start = 1'b0;
        chk(done && mem_addr == 16'h1005 && !mem_wr, "R10 start ignored", mem_addr, 16'h1005);
        @(negedge clk);
        chk(!busy && !mem_wr, "R10 no second request", busy, 0);

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule